// File: doc/BRIEF.md
# Write-Triggered Mailbox Interrupt Controller

This block holds a bank of 64-bit mailboxes behind a simple single-cycle register bus. A data write to a mailbox does not simply store the written value. It is combined with the current content according to the mailbox's input mode: replace, bitwise OR, or add. The post-update value is then tested against the mailbox's trigger rule, and the mailbox's interrupt is raised when the rule holds.

Software or any bus agent can therefore signal an interrupt by writing to memory, as a message-signalled interrupt does. Counting barriers, flag accumulation and threshold alarms all come from the same hardware. Each mailbox drives one sticky interrupt line, and software clears that line through an acknowledge register.

The mailbox count is a parameter and must be a power of two, at least 2. The address is a 64-bit word index. Its two top bits pick a region and its low bits pick the mailbox.

Top module: `mbox_irq_ctrl`

## Requirements
- R1: While `rst_ni` is low, and after its release, every mailbox content and trigger value is zero, every mode and rule field is 0, `irq_o` is all zero and `rvalid_o` is low.
- R2: The address `addr_i` is {region[1:0], index}. The regions are: 0 for mailbox content, 1 for configuration, 2 for trigger value and 3 for pending/acknowledge. In configuration, bits [1:0] hold the mode and bits [3:2] hold the rule; other bits read as zero. In region 3, bit 0 reads as the pending flag and other bits read as zero. A read (`req_i`=1, `we_i`=0) returns its word on `rdata_o` with `rvalid_o`=1 in the next cycle.
- R3: With mode 0 (replace), a content write stores the written word. Mode code 3 also behaves as replace.
- R4: With mode 1 (OR), a content write stores the old content OR the written word.
- R5: With mode 2 (add), a content write stores the old content plus the written word, modulo 2^64.
- R6: With rule 0 (doorbell), every content write sets the mailbox's pending flag, even if the value does not change.
- R7: With rule 1 (match), a content write sets pending only when the updated value equals the trigger value, and the updated value is kept.
- R8: With rule 2 (barrier), pending is set under the same condition as match. When it fires, the content becomes zero; otherwise the updated value is kept.
- R9: With rule 3 (threshold), pending is set when the updated value is greater than or equal to the trigger value, compared as unsigned numbers.
- R10: `irq_o[i]` is mailbox i's pending flag. It stays set until a write to region 3 of mailbox i with bit 0 set clears it. A write there with bit 0 clear has no effect.
- R11: Pending flags are set only by content writes. Reads of any region and writes of configuration or trigger values never change any pending flag or content.
- R12: A write to one mailbox leaves every other mailbox's content, configuration and pending flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Bus access request |
| we_i | input | 1 | Write when 1, read when 0 |
| addr_i | input | log2(N)+2 | Region and mailbox index |
| wdata_i | input | 64 | Write word |
| rdata_o | output | 64 | Read word, registered |
| rvalid_o | output | 1 | Read word valid |
| irq_o | output | N | Per-mailbox sticky interrupt |

## Verification
The bench builds the controller with 8 mailboxes instead of 128. That keeps the address at 5 bits, so one directed scenario can give every mailbox its own mode and rule. It can then confirm, at the bus and on the interrupt lines, that mailboxes do not disturb each other. The 64-bit data width is kept at its default, so add wrap-around and unsigned threshold comparison near the sign bit are tested at full width.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  typedef enum logic [1:0] {
    MODE_SET  = 2'd0,
    MODE_OR   = 2'd1,
    MODE_ADD  = 2'd2,
    MODE_RSVD = 2'd3
  } mode_e;

  typedef enum logic [1:0] {
    COND_BELL    = 2'd0,
    COND_EQ      = 2'd1,
    COND_BARRIER = 2'd2,
    COND_GE      = 2'd3
  } cond_e;

  typedef enum logic [1:0] {
    REG_DATA = 2'd0,
    REG_CFG  = 2'd1,
    REG_TRIG = 2'd2,
    REG_PEND = 2'd3
  } region_e;
endpackage

// File: rtl/mbox_decode.sv
module mbox_decode
  import mbox_pkg::*;
#(
  parameter int unsigned IDX_W = 7,
  localparam int unsigned AW   = IDX_W + 2
) (
  input  logic             req_i,
  input  logic             we_i,
  input  logic [AW-1:0]    addr_i,
  output logic [IDX_W-1:0] idx_o,
  output region_e          region_o,
  output logic             wr_data_o,
  output logic             wr_cfg_o,
  output logic             wr_trig_o,
  output logic             wr_ack_o,
  output logic             rd_o
);
  logic wr;

  assign idx_o    = addr_i[IDX_W-1:0];
  assign region_o = region_e'(addr_i[AW-1:AW-2]);
  assign wr       = req_i & we_i;
  assign rd_o     = req_i & ~we_i;

  always_comb begin
    wr_data_o = 1'b0;
    wr_cfg_o  = 1'b0;
    wr_trig_o = 1'b0;
    wr_ack_o  = 1'b0;
    unique case (region_o)
      REG_DATA: wr_data_o = wr;
      REG_CFG:  wr_cfg_o  = wr;
      REG_TRIG: wr_trig_o = wr;
      REG_PEND: wr_ack_o  = wr;
      default: ;
    endcase
  end
endmodule

// File: rtl/mbox_update.sv
module mbox_update
  import mbox_pkg::*;
#(
  parameter int unsigned DW = 64
) (
  input  logic [DW-1:0] old_i,
  input  logic [DW-1:0] wdata_i,
  input  mode_e         mode_i,
  input  cond_e         cond_i,
  input  logic [DW-1:0] trig_i,
  output logic [DW-1:0] next_o,
  output logic          fire_o
);
  logic [DW-1:0] merged;
  logic          eq;
  logic          ge;

  always_comb begin
    unique case (mode_i)
      MODE_OR:  merged = old_i | wdata_i;
      MODE_ADD: merged = old_i + wdata_i;  // wraps mod 2^DW
      default:  merged = wdata_i;          // set and reserved code
    endcase
  end

  assign eq = (merged == trig_i);
  assign ge = (merged >= trig_i);

  always_comb begin
    fire_o = 1'b0;
    next_o = merged;
    unique case (cond_i)
      COND_BELL: fire_o = 1'b1;
      COND_EQ:   fire_o = eq;
      COND_BARRIER: begin
        fire_o = eq;
        if (eq) next_o = '0;
      end
      COND_GE:   fire_o = ge;
      default: ;
    endcase
  end
endmodule

// File: rtl/mbox_slot.sv
module mbox_slot
  import mbox_pkg::*;
#(
  parameter int unsigned DW = 64
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_data_i,
  input  logic          wr_cfg_i,
  input  logic          wr_trig_i,
  input  logic          wr_ack_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [DW-1:0] next_i,
  input  logic          fire_i,
  output logic [DW-1:0] data_o,
  output mode_e         mode_o,
  output cond_e         cond_o,
  output logic [DW-1:0] trig_o,
  output logic          pend_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o <= '0;
      mode_o <= MODE_SET;
      cond_o <= COND_BELL;
      trig_o <= '0;
      pend_o <= 1'b0;
    end else begin
      if (wr_data_i) begin
        data_o <= next_i;
        if (fire_i) pend_o <= 1'b1;
      end
      if (wr_cfg_i) begin
        mode_o <= mode_e'(wdata_i[1:0]);
        cond_o <= cond_e'(wdata_i[3:2]);
      end
      if (wr_trig_i) trig_o <= wdata_i;
      if (wr_ack_i && wdata_i[0]) pend_o <= 1'b0;
    end
  end
endmodule

// File: rtl/mbox_irq_ctrl.sv
module mbox_irq_ctrl
  import mbox_pkg::*;
#(
  parameter int unsigned N     = 128,
  parameter int unsigned DW    = 64,
  localparam int unsigned IDX_W = $clog2(N),
  localparam int unsigned AW    = IDX_W + 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          rvalid_o,
  output logic [N-1:0]  irq_o
);
  logic [IDX_W-1:0] idx;
  region_e          region;
  logic             wr_data, wr_cfg, wr_trig, wr_ack, rd;

  logic [DW-1:0] data_q [N];
  logic [DW-1:0] trig_q [N];
  mode_e         mode_q [N];
  cond_e         cond_q [N];

  logic [DW-1:0] next_val;
  logic          fire;
  logic [DW-1:0] rd_word;

  mbox_decode #(.IDX_W(IDX_W)) dec_i (
    .req_i     (req_i),
    .we_i      (we_i),
    .addr_i    (addr_i),
    .idx_o     (idx),
    .region_o  (region),
    .wr_data_o (wr_data),
    .wr_cfg_o  (wr_cfg),
    .wr_trig_o (wr_trig),
    .wr_ack_o  (wr_ack),
    .rd_o      (rd)
  );

  // one shared update path: only the addressed mailbox can be written per cycle
  mbox_update #(.DW(DW)) upd_i (
    .old_i   (data_q[idx]),
    .wdata_i (wdata_i),
    .mode_i  (mode_q[idx]),
    .cond_i  (cond_q[idx]),
    .trig_i  (trig_q[idx]),
    .next_o  (next_val),
    .fire_o  (fire)
  );

  for (genvar g = 0; g < N; g++) begin : g_slot
    logic sel;
    assign sel = (idx == IDX_W'(g));
    mbox_slot #(.DW(DW)) slot_i (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_data_i (wr_data & sel),
      .wr_cfg_i  (wr_cfg & sel),
      .wr_trig_i (wr_trig & sel),
      .wr_ack_i  (wr_ack & sel),
      .wdata_i   (wdata_i),
      .next_i    (next_val),
      .fire_i    (fire),
      .data_o    (data_q[g]),
      .mode_o    (mode_q[g]),
      .cond_o    (cond_q[g]),
      .trig_o    (trig_q[g]),
      .pend_o    (irq_o[g])
    );
  end

  always_comb begin
    rd_word = '0;
    unique case (region)
      REG_DATA: rd_word = data_q[idx];
      REG_CFG: begin
        rd_word[1:0] = mode_q[idx];
        rd_word[3:2] = cond_q[idx];
      end
      REG_TRIG: rd_word = trig_q[idx];
      REG_PEND: rd_word[0] = irq_o[idx];
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_o <= 1'b0;
      rdata_o  <= '0;
    end else begin
      rvalid_o <= rd;
      if (rd) rdata_o <= rd_word;
    end
  end
endmodule

// File: rtl/mbox_irq_ctrl_chk.sv
module mbox_irq_ctrl_chk #(
  parameter int unsigned N     = 128,
  parameter int unsigned DW    = 64,
  localparam int unsigned IDX_W = $clog2(N),
  localparam int unsigned AW    = IDX_W + 2
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_i,
  input logic          we_i,
  input logic [AW-1:0] addr_i,
  input logic          wbit0_i,
  input logic [DW-1:0] rdata_o,
  input logic          rvalid_o,
  input logic [N-1:0]  irq_o
);
  logic data_wr, ack_wr, rd_req;
  assign data_wr = req_i && we_i && (addr_i[AW-1:AW-2] == 2'd0);
  assign ack_wr  = req_i && we_i && (addr_i[AW-1:AW-2] == 2'd3) && wbit0_i;
  assign rd_req  = req_i && !we_i;

  // R2
  rd_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req |=> rvalid_o);

  // R2
  rd_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_req |=> !rvalid_o);

  // R2
  pend_rd_bits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req && addr_i[AW-1:AW-2] == 2'd3) |=> (rdata_o[DW-1:1] == '0));

  // R11
  irq_rise_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(irq_o & ~$past(irq_o))) |-> $past(data_wr));

  // R10
  irq_fall_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(~irq_o & $past(irq_o))) |-> $past(ack_wr));

  // R10
  ack_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_wr |=> !irq_o[$past(addr_i[IDX_W-1:0])]);

  // R11
  irq_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && we_i) |=> $stable(irq_o));
endmodule

bind mbox_irq_ctrl mbox_irq_ctrl_chk #(.N(N), .DW(DW)) chk_i (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .req_i    (req_i),
  .we_i     (we_i),
  .addr_i   (addr_i),
  .wbit0_i  (wdata_i[0]),
  .rdata_o  (rdata_o),
  .rvalid_o (rvalid_o),
  .irq_o    (irq_o)
);

// File: tb/mbox_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module mbox_irq_ctrl_tb_top;
  localparam int unsigned N  = 8;
  localparam int unsigned DW = 64;
  localparam int unsigned IW = $clog2(N);
  localparam int unsigned AW = IW + 2;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          req_i = 1'b0;
  logic          we_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [DW-1:0] wdata_i = '0;
  logic [DW-1:0] rdata_o;
  logic          rvalid_o;
  logic [N-1:0]  irq_o;

  int checks = 0;
  int errors = 0;

  always #4 clk_i = ~clk_i;

  mbox_irq_ctrl #(.N(N), .DW(DW)) dut_i (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i, .rdata_o, .rvalid_o, .irq_o
  );

  function automatic logic [AW-1:0] a(input logic [1:0] rg, input int idx);
    return {rg, IW'(idx)};
  endfunction

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] rg, input int idx, input logic [63:0] d);
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b1; addr_i = a(rg, idx); wdata_i = d;
    @(negedge clk_i);
    req_i = 1'b0; we_i = 1'b0; wdata_i = '0;
  endtask

  task automatic rd(input logic [1:0] rg, input int idx, output logic [63:0] d);
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b0; addr_i = a(rg, idx);
    @(negedge clk_i);
    req_i = 1'b0;
    d = rdata_o;
    chk("R2 rvalid", {63'b0, rvalid_o}, 64'd1);
  endtask

  task automatic t_reset();
    logic [63:0] d;
    chk("R1 irq", {56'b0, irq_o}, 64'd0);
    chk("R1 rvalid", {63'b0, rvalid_o}, 64'd0);
    rd(2'd0, 3, d); chk("R1 data", d, 64'd0);
    rd(2'd1, 3, d); chk("R1 cfg", d, 64'd0);
    rd(2'd2, 5, d); chk("R1 trig", d, 64'd0);
    @(negedge clk_i);
    chk("R2 rvalid drops", {63'b0, rvalid_o}, 64'd0);
  endtask

  task automatic t_modes();
    logic [63:0] d;
    for (int i = 1; i <= 3; i++) begin
      wr(2'd2, i, 64'hDEAD_0000_0000_BEEF);
      wr(2'd1, i, {60'b0, 2'd1, 2'(i - 1)});  // rule match, mode i-1
    end
    wr(2'd0, 1, 64'h1234); wr(2'd0, 1, 64'h55);
    rd(2'd0, 1, d); chk("R3 replace", d, 64'h55);
    wr(2'd0, 2, 64'hF0); wr(2'd0, 2, 64'h0F);
    rd(2'd0, 2, d); chk("R4 or", d, 64'hFF);
    wr(2'd0, 3, 64'd5); wr(2'd0, 3, 64'd7);
    rd(2'd0, 3, d); chk("R5 add", d, 64'd12);
    wr(2'd0, 3, '1);
    rd(2'd0, 3, d); chk("R5 add wrap", d, 64'd11);
    chk("R7 no match no irq", {56'b0, irq_o}, 64'd0);
    rd(2'd1, 2, d); chk("R2 cfg read", d, 64'h5);
  endtask

  task automatic t_doorbell();
    logic [63:0] d;
    wr(2'd0, 4, 64'd0);
    chk("R6 doorbell fires", {63'b0, irq_o[4]}, 64'd1);
    rd(2'd3, 4, d); chk("R2 pend read", d, 64'd1);
    wr(2'd3, 4, 64'h2);
    chk("R10 ack bit0 clear ignored", {63'b0, irq_o[4]}, 64'd1);
    wr(2'd3, 4, 64'h1);
    chk("R10 ack clears", {63'b0, irq_o[4]}, 64'd0);
    wr(2'd0, 4, 64'd0);
    chk("R6 same value fires", {63'b0, irq_o[4]}, 64'd1);
    chk("R12 other lines", {56'b0, irq_o}, 64'h10);
    wr(2'd3, 4, 64'h1);
  endtask

  task automatic t_match();
    logic [63:0] d;
    wr(2'd2, 5, 64'd10);
    wr(2'd1, 5, {60'b0, 2'd1, 2'd2});
    wr(2'd0, 5, 64'd4);
    chk("R7 below no fire", {63'b0, irq_o[5]}, 64'd0);
    wr(2'd0, 5, 64'd6);
    chk("R7 equal fires", {63'b0, irq_o[5]}, 64'd1);
    rd(2'd0, 5, d); chk("R7 content kept", d, 64'd10);
    wr(2'd0, 5, 64'd1);
    chk("R10 sticky", {63'b0, irq_o[5]}, 64'd1);
    wr(2'd3, 5, 64'h1);
    chk("R10 ack", {63'b0, irq_o[5]}, 64'd0);
  endtask

  task automatic t_barrier();
    logic [63:0] d;
    wr(2'd2, 6, 64'd3);
    wr(2'd1, 6, {60'b0, 2'd2, 2'd2});
    wr(2'd0, 6, 64'd1);
    chk("R8 no fire", {63'b0, irq_o[6]}, 64'd0);
    rd(2'd0, 6, d); chk("R8 kept", d, 64'd1);
    wr(2'd0, 6, 64'd2);
    chk("R8 fires", {63'b0, irq_o[6]}, 64'd1);
    rd(2'd0, 6, d); chk("R8 cleared", d, 64'd0);
    wr(2'd3, 6, 64'h1);
  endtask

  task automatic t_threshold();
    wr(2'd2, 7, 64'h8000_0000_0000_0000);
    wr(2'd1, 7, {60'b0, 2'd3, 2'd0});
    wr(2'd0, 7, 64'h7FFF_FFFF_FFFF_FFFF);
    chk("R9 below unsigned", {63'b0, irq_o[7]}, 64'd0);
    wr(2'd0, 7, 64'h8000_0000_0000_0000);
    chk("R9 equal fires", {63'b0, irq_o[7]}, 64'd1);
    wr(2'd3, 7, 64'h1);
    wr(2'd0, 7, '1);
    chk("R9 above fires", {63'b0, irq_o[7]}, 64'd1);
    wr(2'd3, 7, 64'h1);
  endtask

  task automatic t_side();
    logic [63:0] d;
    rd(2'd0, 7, d); rd(2'd0, 7, d);
    chk("R11 read no side effect", d, '1);
    wr(2'd2, 0, 64'd9);
    wr(2'd1, 0, '1);
    chk("R11 cfg write no irq", {56'b0, irq_o}, 64'd0);
    rd(2'd1, 0, d); chk("R2 cfg upper zero", d, 64'hF);
    rd(2'd0, 1, d); chk("R12 neighbour kept", d, 64'h55);
    rd(2'd0, 0, d); chk("R11 content unchanged", d, 64'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_modes();
    t_doorbell();
    t_match();
    t_barrier();
    t_threshold();
    t_side();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule